// File: doc/BRIEF.md
# Multi-Mode Logarithmic Shifter

This block is a purely combinational word shifter. It moves a data word left or right by a count of 0 to W-1 places. The fill rule is one of three: zero fill, sign fill, or rotation. W is a power-of-two parameter and is 8 by default. The datapath has log2(W) cascaded multiplexer stages. Stage k moves the word by 2^k places when bit k of the count is set. A count of 13 on a wide word therefore passes through the 1, 4 and 8 stages.

A single control decode turns the mode and direction inputs into one stage operation. Every stage shares that operation. The fill bit for sign-extending shifts is taken from the most significant bit of the original input. The block has no registers, no clock and no status outputs. An ALU or address unit places it inside its own timing path.

Top module: `mshift_top`

## Requirements
- R1: With `mode` = 2'b00 (zero fill) and `dir_right` = 0, `dout` equals `din` moved toward the MSB by `shamt` places. The vacated low bits are 0 and bits leaving the top are lost. Example: 8'h96 by 1 gives 8'h2C.
- R2: With `mode` = 2'b00 and `dir_right` = 1, `dout` equals `din` moved toward the LSB by `shamt` places. The vacated high bits are 0. Example: 8'h96 by 2 gives 8'h25.
- R3: With `mode` = 2'b01 (sign fill) and `dir_right` = 1, the vacated high bits take the value of `din[W-1]`. Example: 8'h96 by 1 gives 8'hCB.
- R4: With `mode` = 2'b01 and `dir_right` = 0, `dout` is identical to the R1 result for the same `din` and `shamt`.
- R5: With `mode` = 2'b10 (rotate) and `dir_right` = 0, each bit leaving the MSB end re-enters at the LSB end. Example: 8'h96 by 1 gives 8'h2D.
- R6: With `mode` = 2'b10 and `dir_right` = 1, each bit leaving the LSB end re-enters at the MSB end.
- R7: With `mode` = 2'b11, `dout` equals `din` for every `shamt` and `dir_right`.
- R8: When `shamt` = 0, `dout` equals `din` in every mode and direction. Each nonzero count gives the same result as that many single-place steps of the selected kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | W | Word to be shifted |
| shamt | input | log2(W) | Shift distance, 0 to W-1 |
| dir_right | input | 1 | 0 = toward MSB, 1 = toward LSB |
| mode | input | 2 | 00 zero fill, 01 sign fill, 10 rotate, 11 pass through |
| dout | output | W | Shifted word |

## Verification
The block holds no state, so an internal fault appears at `dout` in the same evaluation as the stimulus. A wrong operation decode changes the fill or rotation pattern for every nonzero count in the affected mode. A fault in stage k shows only for counts with bit k set. A miswired sign source shows only for negative inputs under sign-fill right shifts. The bench therefore sweeps every data word, count, direction and mode, so every stage is exercised with every fill rule.

// File: rtl/mshift_pkg.sv
package mshift_pkg;

    typedef enum logic [1:0] {
        MODE_ZERO = 2'b00,
        MODE_SIGN = 2'b01,
        MODE_ROT  = 2'b10,
        MODE_HOLD = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        OP_PASS,
        OP_SHL,
        OP_SHR,
        OP_SRA,
        OP_ROL,
        OP_ROR
    } op_e;

    typedef struct packed {
        op_e  op;
        logic fill;
    } stage_ctrl_t;

    function automatic op_e pick_op(input logic [1:0] mode, input logic right);
        op_e r;
        case (mode)
            MODE_ZERO: r = right ? OP_SHR : OP_SHL;
            MODE_SIGN: r = right ? OP_SRA : OP_SHL;
            MODE_ROT:  r = right ? OP_ROR : OP_ROL;
            default:   r = OP_PASS;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mshift_decode.sv
module mshift_decode
    import mshift_pkg::*;
(
    input  logic [1:0]  mode,
    input  logic        dir_right,
    input  logic        msb,
    output stage_ctrl_t ctrl
);
    always_comb begin
        ctrl.op   = pick_op(mode, dir_right);
        ctrl.fill = (ctrl.op == OP_SRA) ? msb : 1'b0;
    end
endmodule

// File: rtl/mshift_stage.sv
module mshift_stage
    import mshift_pkg::*;
#(
    parameter int W    = 8,
    parameter int DIST = 1
) (
    input  logic [W-1:0] w_in,
    input  logic         en,
    input  stage_ctrl_t  ctrl,
    output logic [W-1:0] w_out
);
    logic [W-1:0] moved;

    always_comb begin
        unique case (ctrl.op)
            OP_SHL:  moved = {w_in[W-1-DIST:0], {DIST{1'b0}}};
            OP_SHR:  moved = {{DIST{1'b0}}, w_in[W-1:DIST]};
            OP_SRA:  moved = {{DIST{ctrl.fill}}, w_in[W-1:DIST]};
            OP_ROL:  moved = {w_in[W-1-DIST:0], w_in[W-1:W-DIST]};
            OP_ROR:  moved = {w_in[DIST-1:0], w_in[W-1:DIST]};
            default: moved = w_in;
        endcase
        w_out = en ? moved : w_in;
    end
endmodule

// File: rtl/mshift_top.sv
module mshift_top
    import mshift_pkg::*;
#(
    parameter int W  = 8,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] shamt,
    input  logic          dir_right,
    input  logic [1:0]    mode,
    output logic [W-1:0]  dout
);
    stage_ctrl_t ctrl;
    logic [W-1:0] chain [CW+1];

    mshift_decode dec_i (
        .mode      (mode),
        .dir_right (dir_right),
        .msb       (din[W-1]),
        .ctrl      (ctrl)
    );

    assign chain[0] = din;

    for (genvar k = 0; k < CW; k++) begin : g_stage
        mshift_stage #(.W(W), .DIST(1 << k)) stage_i (
            .w_in  (chain[k]),
            .en    (shamt[k]),
            .ctrl  (ctrl),
            .w_out (chain[k+1])
        );
    end

    assign dout = chain[CW];
endmodule

// File: rtl/mshift_chk.sv
module mshift_chk #(
    parameter int W  = 8,
    localparam int CW = $clog2(W)
) (
    input logic [W-1:0]  din,
    input logic [CW-1:0] shamt,
    input logic          dir_right,
    input logic [1:0]    mode,
    input logic [W-1:0]  dout
);
    logic [2*W-1:0] dbl_l, dbl_r;
    logic [W-1:0]   ref_shl, ref_shr, ref_sra;

    always_comb begin
        dbl_l   = {din, din} << shamt;
        dbl_r   = {din, din} >> shamt;
        ref_shl = din << shamt;
        ref_shr = din >> shamt;
        ref_sra = W'($signed(din) >>> shamt);

        if (mode == 2'b00 && !dir_right)
            p_zero_left_r1: assert (dout == ref_shl);
        if (mode == 2'b00 && dir_right)
            p_zero_right_r2: assert (dout == ref_shr);
        if (mode == 2'b01 && dir_right)
            p_sign_right_r3: assert (dout == ref_sra);
        if (mode == 2'b01 && !dir_right)
            p_sign_left_r4: assert (dout == ref_shl);
        if (mode == 2'b10 && !dir_right)
            p_rot_left_r5: assert (dout == dbl_l[2*W-1:W]);
        if (mode == 2'b10 && dir_right)
            p_rot_right_r6: assert (dout == dbl_r[W-1:0]);
        if (mode == 2'b11)
            p_hold_r7: assert (dout == din);
        if (shamt == '0)
            p_zero_count_r8: assert (dout == din);
    end
endmodule

bind mshift_top mshift_chk #(.W(W)) chk_i (
    .din       (din),
    .shamt     (shamt),
    .dir_right (dir_right),
    .mode      (mode),
    .dout      (dout)
);

// File: tb/mshift_top_tb_top.sv
module mshift_top_tb_top;
    localparam int W  = 8;
    localparam int CW = 3;
    localparam int MAXCYC = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  din = '0;
    logic [CW-1:0] shamt = '0;
    logic          dir_right = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [W-1:0]  dout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mshift_top #(.W(W)) dut_i (
        .din(din), .shamt(shamt), .dir_right(dir_right), .mode(mode), .dout(dout)
    );

    function automatic int expect_of(int d, int c, int right, int m);
        int r = d;
        if (m == 3) return d;
        for (int i = 0; i < c; i++) begin
            if (m == 2) begin
                if (right != 0) r = r / 2 + (r % 2) * 128;
                else            r = (r * 2) % 256 + r / 128;
            end else if (right != 0) begin
                if (m == 1) r = r / 2 + ((r >= 128) ? 128 : 0);
                else        r = r / 2;
            end else begin
                r = (r * 2) % 256;
            end
        end
        return r;
    endfunction

    function automatic string tag_of(int c, int right, int m);
        if (m == 3) return "R7";
        if (c == 0) return "R8";
        case (m)
            0: return right ? "R2" : "R1";
            1: return right ? "R3" : "R4";
            default: return right ? "R6" : "R5";
        endcase
    endfunction

    task automatic apply_check(int d, int c, int right, int m, int exp_v, string tag);
        @(posedge clk);
        din = W'(d); shamt = CW'(c); dir_right = right[0]; mode = m[1:0];
        @(negedge clk);
        checks++;
        if (int'(dout) != exp_v) begin
            errors++;
            $display("FAIL %s din=%02h cnt=%0d right=%0d mode=%0d got=%02h exp=%02h",
                     tag, d, c, right, m, dout, exp_v);
        end
    endtask

    initial begin
        repeat (MAXCYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (dout != '0) begin
            errors++;
            $display("FAIL R8 reset-phase output got=%02h exp=00", dout);
        end
        rst = 1'b0;

        // directed values: R1 R2 R3 R5
        apply_check(8'h96, 1, 0, 0, 8'h2C, "R1");
        apply_check(8'h96, 2, 1, 0, 8'h25, "R2");
        apply_check(8'h96, 1, 1, 1, 8'hCB, "R3");
        apply_check(8'h96, 1, 0, 2, 8'h2D, "R5");
        apply_check(8'h96, 1, 1, 2, 8'h4B, "R6");
        apply_check(8'h96, 3, 0, 1, 8'hB0, "R4");
        apply_check(8'h5A, 7, 1, 3, 8'h5A, "R7");
        apply_check(8'h80, 7, 1, 1, 8'hFF, "R3");

        // exhaustive sweep over all words, counts, directions and modes
        for (int m = 0; m < 4; m++)
            for (int right = 0; right < 2; right++)
                for (int c = 0; c < W; c++)
                    for (int d = 0; d < 256; d++)
                        apply_check(d, c, right, m, expect_of(d, c, right, m),
                                    tag_of(c, right, m));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule